// File: doc/BRIEF.md
# FIFO Fill-Level Watermark and Interrupt Controller

This block sits beside the receive and transmit FIFOs of a serial port. It takes the occupancy counts of both FIFOs and reports each one as a coarse level in quarter steps. The receive level counts how full its FIFO is. The transmit level counts how empty its FIFO is.

For each direction, a programmable urgent threshold raises a watermark flag, and a programmable regular threshold lowers it again. This gives the flag hysteresis. A rising watermark flag, together with single-cycle error and start/finish pulses from the transfer engine, is captured in a sticky latch register. A mask register selects which latched bits drive one combined interrupt line. Software changes the mask only through a set alias and a clear alias. It acknowledges latched events through a write-one-to-clear alias.

Top module: `fifo_wm_irq`

## Requirements
- R1: `rx_lvl` encodes the receive occupancy as follows: 4 when the count equals RX_DEPTH; otherwise 3 when at least 75% full, 2 when at least 50% full, 1 when at least 25% full, else 0. It follows the count in the same cycle.
- R2: `tx_lvl` uses the same encoding applied to the free space (TX_DEPTH minus count). So 0 means full and 4 means empty.
- R3: A watermark flag (`rx_wm`, `tx_wm`) becomes 1 one clock after the level becomes greater than or equal to the urgent code (1..4). Urgent code 0, and codes 5 to 7, hold the flag at 0.
- R4: Once set, a watermark flag stays 1 while its level is above the regular code (0..3). It drops one clock after the level becomes less than or equal to the regular code, unless the level still meets the urgent code.
- R5: The clock edge on which `rx_wm` rises sets latch bit 1. The edge on which `tx_wm` rises sets latch bit 2.
- R6: A pulse on `xfer_evt[k]` sets latch bit k+4 on that clock edge. The mapping is: receive overrun at bit 4, transmit underrun at bit 5, collision at bit 6, mode fault at bit 7, receive start at bit 8, transmit start at bit 9, receive finish at bit 10, transmit finish at bit 11.
- R7: A write with `mask_set_we` sets the mask bits where `wr_data` is 1. A write with `mask_clr_we` clears them. All other bits keep their value, and set wins if both strobes name the same bit. Bits 0 and 3 always read 0.
- R8: Latched bits stay set until a write with `lat_clr_we` clears the bits where `wr_data` is 1. A new event on the same bit in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when some bit is 1 in both `lat_q` and `mask_q`.
- R10: After reset, mask, latch, both watermark flags and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_count | input | $clog2(RX_DEPTH+1) | Receive FIFO occupancy |
| tx_count | input | $clog2(TX_DEPTH+1) | Transmit FIFO occupancy |
| rx_urg_code | input | 3 | Receive urgent watermark code |
| rx_reg_code | input | 2 | Receive regular watermark code |
| tx_urg_code | input | 3 | Transmit urgent watermark code |
| tx_reg_code | input | 2 | Transmit regular watermark code |
| xfer_evt | input | 8 | Single-cycle transfer event pulses, mapped to latch bits 4..11 |
| mask_set_we | input | 1 | Mask set-alias write strobe |
| mask_clr_we | input | 1 | Mask clear-alias write strobe |
| lat_clr_we | input | 1 | Latch write-one-to-clear strobe |
| wr_data | input | 12 | Write data for the three aliases |
| rx_lvl | output | 3 | Receive quarter-step fill level |
| tx_lvl | output | 3 | Transmit quarter-step empty level |
| rx_wm | output | 1 | Receive watermark flag |
| tx_wm | output | 1 | Transmit watermark flag |
| mask_q | output | 12 | Interrupt mask register |
| lat_q | output | 12 | Interrupt latch register |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that each occupancy count never exceeds its FIFO depth. One assertion checks exactly this input bound. The hysteresis properties also assume that the watermark codes are held steady while a flag is set. The stimulus therefore changes the codes only when a test phase starts, and walks the counts only between 0 and the depth. Within those limits it sweeps the levels up and down across every quarter boundary. It fires transfer pulses at random, and it deliberately collides clears with new events and mask set with mask clear.

// File: rtl/fwi_pkg.sv
package fwi_pkg;
    localparam int EVW       = 12;
    localparam int XFW       = 8;
    localparam int LVLW      = 3;
    localparam int BIT_RX_WM = 1;
    localparam int BIT_TX_WM = 2;
    localparam int XFER_BASE = 4;
    localparam logic [EVW-1:0] VALID_BITS = 12'hFF6;

    typedef struct packed {
        logic [EVW-1:0] mask;
        logic [EVW-1:0] lat;
    } irq_state_t;

    typedef struct packed {
        logic flag;
    } wm_state_t;
endpackage

// File: rtl/fwi_level_quant.sv
module fwi_level_quant #(
    parameter int DEPTH  = 16,
    parameter bit INVERT = 1'b0,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          count,
    output logic [fwi_pkg::LVLW-1:0] lvl
);
    localparam int AW = CW + 3;
    localparam logic [AW-1:0] Q1 = AW'(DEPTH);
    localparam logic [AW-1:0] Q2 = AW'(2 * DEPTH);
    localparam logic [AW-1:0] Q3 = AW'(3 * DEPTH);

    logic [CW-1:0] amount;
    logic [AW-1:0] amount_x4;

    generate
        if (INVERT) begin : g_empty
            assign amount = CW'(DEPTH) - count;
        end else begin : g_full
            assign amount = count;
        end
    endgenerate

    assign amount_x4 = {3'b000, amount} << 2;

    always_comb begin
        if (amount == CW'(DEPTH))  lvl = 3'd4;
        else if (amount_x4 >= Q3)  lvl = 3'd3;
        else if (amount_x4 >= Q2)  lvl = 3'd2;
        else if (amount_x4 >= Q1)  lvl = 3'd1;
        else                       lvl = 3'd0;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
endmodule

// File: rtl/fwi_wm_hyst.sv
module fwi_wm_hyst
    import fwi_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] lvl,
    input  logic [2:0]      urg_code,
    input  logic [1:0]      reg_code,
    output logic            flag_q,
    output logic            rise
);
    wm_state_t st_d, st_q;
    logic      urg_on;

    always_comb begin
        urg_on = (urg_code != 3'd0) && (urg_code <= 3'd4);
        st_d   = st_q;
        if (!urg_on)
            st_d.flag = 1'b0;
        else if (lvl >= urg_code)
            st_d.flag = 1'b1;
        else if (lvl <= {1'b0, reg_code})
            st_d.flag = 1'b0;
        rise = st_d.flag & ~st_q.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q = st_q.flag;

    AST_URG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (urg_code == 3'd0) |=> !flag_q); // R3
    AST_URG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (urg_code != 3'd0 && urg_code <= 3'd4 && lvl >= urg_code) |=> flag_q); // R3
    AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && urg_code != 3'd0 && urg_code <= 3'd4 && lvl > {1'b0, reg_code}) |=> flag_q); // R4
endmodule

// File: rtl/fwi_irq_regs.sv
module fwi_irq_regs
    import fwi_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [EVW-1:0] evt,
    input  logic           mask_set_we,
    input  logic           mask_clr_we,
    input  logic           lat_clr_we,
    input  logic [EVW-1:0] wr_data,
    output logic [EVW-1:0] mask_q,
    output logic [EVW-1:0] lat_q,
    output logic           irq
);
    irq_state_t     st_d, st_q;
    logic [EVW-1:0] wr_valid;

    always_comb begin
        wr_valid = wr_data & VALID_BITS;
        st_d     = st_q;
        if (mask_clr_we) st_d.mask = st_d.mask & ~wr_valid;
        if (mask_set_we) st_d.mask = st_d.mask | wr_valid;
        if (lat_clr_we)  st_d.lat  = st_d.lat & ~wr_valid;
        st_d.lat = st_d.lat | (evt & VALID_BITS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q = st_q.mask;
    assign lat_q  = st_q.lat;
    assign irq    = |(st_q.mask & st_q.lat);

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mask_set_we |=> ((mask_q & $past(wr_data & VALID_BITS)) == $past(wr_data & VALID_BITS))); // R7
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_set_we && !mask_clr_we) |=> $stable(mask_q)); // R7
    AST_LAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_clr_we |=> ((lat_q & $past(lat_q)) == $past(lat_q))); // R8
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((lat_q & $past(evt & VALID_BITS)) == $past(evt & VALID_BITS))); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_q & mask_q) == '0) |-> !irq); // R9
endmodule

// File: rtl/fifo_wm_irq.sv
module fifo_wm_irq
    import fwi_pkg::*;
#(
    parameter int RX_DEPTH = 16,
    parameter int TX_DEPTH = 16,
    localparam int RCW     = $clog2(RX_DEPTH + 1),
    localparam int TCW     = $clog2(TX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RCW-1:0]  rx_count,
    input  logic [TCW-1:0]  tx_count,
    input  logic [2:0]      rx_urg_code,
    input  logic [1:0]      rx_reg_code,
    input  logic [2:0]      tx_urg_code,
    input  logic [1:0]      tx_reg_code,
    input  logic [7:0]      xfer_evt,
    input  logic            mask_set_we,
    input  logic            mask_clr_we,
    input  logic            lat_clr_we,
    input  logic [11:0]     wr_data,
    output logic [2:0]      rx_lvl,
    output logic [2:0]      tx_lvl,
    output logic            rx_wm,
    output logic            tx_wm,
    output logic [11:0]     mask_q,
    output logic [11:0]     lat_q,
    output logic            irq
);
    logic           rx_rise, tx_rise;
    logic [EVW-1:0] evt;

    fwi_level_quant #(.DEPTH(RX_DEPTH), .INVERT(1'b0)) i_rx_quant (
        .clk(clk), .rst_n(rst_n), .count(rx_count), .lvl(rx_lvl));
    fwi_level_quant #(.DEPTH(TX_DEPTH), .INVERT(1'b1)) i_tx_quant (
        .clk(clk), .rst_n(rst_n), .count(tx_count), .lvl(tx_lvl));

    fwi_wm_hyst i_rx_wm (
        .clk(clk), .rst_n(rst_n), .lvl(rx_lvl), .urg_code(rx_urg_code),
        .reg_code(rx_reg_code), .flag_q(rx_wm), .rise(rx_rise));
    fwi_wm_hyst i_tx_wm (
        .clk(clk), .rst_n(rst_n), .lvl(tx_lvl), .urg_code(tx_urg_code),
        .reg_code(tx_reg_code), .flag_q(tx_wm), .rise(tx_rise));

    always_comb begin
        evt = '0;
        evt[BIT_RX_WM] = rx_rise;
        evt[BIT_TX_WM] = tx_rise;
        for (int k = 0; k < XFW; k++)
            evt[XFER_BASE + k] = xfer_evt[k];
    end

    fwi_irq_regs i_regs (
        .clk(clk), .rst_n(rst_n), .evt(evt), .mask_set_we(mask_set_we),
        .mask_clr_we(mask_clr_we), .lat_clr_we(lat_clr_we), .wr_data(wr_data),
        .mask_q(mask_q), .lat_q(lat_q), .irq(irq));

    AST_RISE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_wm) |-> lat_q[BIT_RX_WM]); // R5
endmodule

// File: tb/test_fifo_wm_irq.sv
module test_fifo_wm_irq;
    localparam int CLK_PERIOD = 10;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rx_count = '0, tx_count = '0;
    logic [2:0]  rx_urg_code = '0, tx_urg_code = '0;
    logic [1:0]  rx_reg_code = '0, tx_reg_code = '0;
    logic [7:0]  xfer_evt = '0;
    logic        mask_set_we = 1'b0, mask_clr_we = 1'b0, lat_clr_we = 1'b0;
    logic [11:0] wr_data = '0;
    logic [2:0]  rx_lvl, tx_lvl;
    logic        rx_wm, tx_wm, irq;
    logic [11:0] mask_q, lat_q;

    int tests = 0, fails = 0;
    bit done = 0;

    // reference state
    int m_rxf = 0, m_txf = 0, m_mask = 0, m_lat = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fifo_wm_irq i_fifo_wm_irq (.*);

    function automatic int qlvl(int amt);
        if (amt == D) return 4;
        if (4*amt >= 3*D) return 3;
        if (4*amt >= 2*D) return 2;
        if (4*amt >= D) return 1;
        return 0;
    endfunction

    function automatic int next_flag(int cur, int lvl, int u, int r);
        if (u == 0 || u > 4) return 0;
        if (lvl >= u) return 1;
        if (lvl <= r) return 0;
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rxf = 0; m_txf = 0; m_mask = 0; m_lat = 0;
        end else begin
            int nr, nt, ev;
            nr = next_flag(m_rxf, qlvl(int'(rx_count)), int'(rx_urg_code), int'(rx_reg_code));
            nt = next_flag(m_txf, qlvl(D - int'(tx_count)), int'(tx_urg_code), int'(tx_reg_code));
            ev = (int'(xfer_evt) << 4) | ((nr != 0 && m_rxf == 0) ? 2 : 0)
                 | ((nt != 0 && m_txf == 0) ? 4 : 0);
            if (mask_clr_we) m_mask = m_mask & ~(int'(wr_data) & 'hFF6);
            if (mask_set_we) m_mask = m_mask | (int'(wr_data) & 'hFF6);
            if (lat_clr_we)  m_lat  = m_lat & ~(int'(wr_data) & 'hFF6);
            m_lat = (m_lat | ev) & 'hFF6;
            m_rxf = nr; m_txf = nt;
        end
    end

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R1 rx_lvl", int'(rx_lvl), qlvl(int'(rx_count)));
        chk("R2 tx_lvl", int'(tx_lvl), qlvl(D - int'(tx_count)));
        chk("R3/R4 rx_wm", int'(rx_wm), m_rxf);
        chk("R3/R4 tx_wm", int'(tx_wm), m_txf);
        chk("R7 mask", int'(mask_q), m_mask);
        chk("R5/R6/R8 latch", int'(lat_q), m_lat);
        chk("R9 irq", int'(irq), ((m_lat & m_mask) != 0) ? 1 : 0);
    endtask

    // advance one cycle: check at negedge, then drive new inputs
    task automatic step();
        @(negedge clk);
        compare_all();
        xfer_evt = '0; mask_set_we = 0; mask_clr_we = 0; lat_clr_we = 0; wr_data = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        tx_count = 5'(D);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 mask reset", int'(mask_q), 0);
        chk("R10 latch reset", int'(lat_q), 0);
        chk("R10 flags reset", int'({rx_wm, tx_wm}), 0);
        chk("R10 irq reset", int'(irq), 0);
        rst_n = 1'b1;
        step();

        // R1 sweep receive count up and down, urgent 3, regular 1
        rx_urg_code = 3; rx_reg_code = 1;
        for (int c = 0; c <= D; c++) begin rx_count = 5'(c); step(); end
        for (int c = D; c >= 0; c--) begin rx_count = 5'(c); step(); end
        // R4 hold: rise to lvl 3, fall to lvl 2 (held), then to lvl 1 (drops)
        rx_count = 12; step(); step();
        rx_count = 9;  step(); step();
        chk("R4 rx_wm held above regular", int'(rx_wm), 1);
        rx_count = 5;  step(); step();
        chk("R4 rx_wm dropped at regular", int'(rx_wm), 0);
        // R3 code 0 disables; code 4 needs full
        rx_urg_code = 0; rx_count = 5'(D); step(); step();
        chk("R3 urgent disabled", int'(rx_wm), 0);
        rx_urg_code = 4; rx_count = 15; step(); step();
        chk("R3 below full", int'(rx_wm), 0);
        rx_count = 5'(D); step(); step();
        chk("R3 at full", int'(rx_wm), 1);
        chk("R5 rx latch bit 1", int'(lat_q[1]), 1);
        rx_urg_code = 0; rx_count = 0; step();

        // R2 transmit sweep: count down is emptying
        tx_urg_code = 2; tx_reg_code = 0;
        for (int c = D; c >= 0; c--) begin tx_count = 5'(c); step(); end
        chk("R5 tx latch bit 2", int'(lat_q[2]), 1);
        for (int c = 0; c <= D; c++) begin tx_count = 5'(c); step(); end
        chk("R2 full tx level", int'(tx_lvl), 0);

        // R7 mask aliases, set wins on collision, reserved bits stay 0
        wr_data = 12'hFFF; mask_set_we = 1; step();
        chk("R7 set all valid", int'(mask_q), 'hFF6);
        wr_data = 12'h0F0; mask_clr_we = 1; step();
        chk("R7 clear subset", int'(mask_q), 'hF06);
        wr_data = 12'h300; mask_clr_we = 1; mask_set_we = 1; step();
        chk("R7 set wins", int'(mask_q), 'hF06);
        step();

        // R8 clear all, then collide clear with event on bit 4
        wr_data = 12'hFFF; lat_clr_we = 1; step();
        chk("R8 cleared", int'(lat_q), 0);
        chk("R9 irq low", int'(irq), 0);
        xfer_evt = 8'h01; wr_data = 12'h010; lat_clr_we = 1; step();
        chk("R8 event beats clear", int'(lat_q[4]), 1);
        chk("R9 bit4 masked off", int'(irq), 0);
        xfer_evt = 8'h80; step();
        chk("R6 tx finish bit 11", int'(lat_q[11]), 1);
        chk("R9 irq raised", int'(irq), 1);

        // R6 random mix of pulses, writes, and counts
        rx_urg_code = 3; rx_reg_code = 2; tx_urg_code = 1; tx_reg_code = 0;
        for (int i = 0; i < 2000; i++) begin
            xfer_evt    = 8'($urandom);
            mask_set_we = ($urandom % 4) == 0;
            mask_clr_we = ($urandom % 4) == 0;
            lat_clr_we  = ($urandom % 3) == 0;
            wr_data     = 12'($urandom);
            if (($urandom % 3) == 0) rx_count = 5'($urandom % (D + 1));
            if (($urandom % 3) == 0) tx_count = 5'($urandom % (D + 1));
            @(negedge clk);
            compare_all();
        end
        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule